// File: doc/BRIEF.md
# ADC Sample-and-Convert Sequencer

This controller steps a successive-approximation converter through its two phases: acquisition, then conversion. It derives a conversion clock period (one "Tad") from the system clock through a programmable divider. It then picks the event that ends acquisition and starts conversion. That event can be a software release, a programmable auto-start count, or one of three external event lines (timer, PWM, interrupt). At the end of a conversion it captures the converter's result word into a buffer, pulses a done flag and steps a channel index. The converter's analog front end and its bit-serial data path sit outside this block. They are represented by a result word on `conv_data`, which is captured when a conversion completes.

Dropping the enable input during acquisition or conversion aborts the sequence. The buffer keeps its last completed value, and a lockout of two conversion clocks must pass before a new acquisition can begin. The channel index skips past the aborted slot, so a sequential scan resumes on the next channel.

Top module: `adc_seq_ctrl`

## Requirements
- R1: One conversion clock period (Tad) lasts `clk_div + 1` system clocks. Every phase starts on a fresh Tad boundary.
- R2: With `src_sel` = 000 (software), a conversion starts on the first edge in acquisition at which `samp_req` is low.
- R3: With `src_sel` = 111 (auto), a conversion starts `samp_clks` Tad after acquisition begins, and a `samp_clks` of 0 behaves as 1. With `samp_clks` = 1, the sample-plus-convert period is 13 Tad.
- R4: Codes 001, 010 and 011 select `trig_tmr`, `trig_pwm` and `trig_ext`. Each line passes through a two-flop synchroniser and a rising-edge detector, so a conversion starts on the third edge after the line rises. Codes 100 to 110 never start a conversion.
- R5: A conversion lasts 12 Tad. On its final edge `result` takes `conv_data` and `done` rises for exactly one system clock.
- R6: Taking `en` low during acquisition or conversion aborts without writing `result` or pulsing `done`. The abort wins over an auto-start that falls due on the same edge.
- R7: After an abort the controller stays locked for 2 Tad, and `samp_req` has no effect during that time. Acquisition begins on the first edge after the lockout at which `en` and `samp_req` are both high.
- R8: `chan` advances by one on every result write and on every abort, wrapping from `NCH-1` to 0.
- R9: While `rst_n` is low, `result`, `done` and `chan` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable; low aborts |
| samp_req | input | 1 | Starts acquisition from idle; software trigger when released |
| src_sel | input | 3 | Trigger source select |
| samp_clks | input | SAMC_W | Auto-start acquisition length in Tad |
| clk_div | input | DIV_W | Conversion clock divider setting |
| trig_tmr | input | 1 | Timer event line (asynchronous) |
| trig_pwm | input | 1 | PWM event line (asynchronous) |
| trig_ext | input | 1 | External interrupt event line (asynchronous) |
| conv_data | input | DATA_W | Result word from the converter data path |
| result | output | DATA_W | Result buffer |
| done | output | 1 | One-clock pulse when `result` is written |
| chan | output | CH_W | Index of the next channel |

## Verification
The bench builds the block with a channel count of 3, so the channel index has to wrap at a value that is not a power of two. The divider and sample-count widths stay at 6 and 5 bits. This covers divider settings from 0 up to the maximum of 63 and sample counts of 0, 1, 3 and 4 within a short run. Every expected done-pulse cycle is computed in Tad from the requirements. As a result, a lockout or sample count that is off by one, or a wrong trigger priority, appears as a pulse in the wrong cycle.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DIV_W    = 6,
  parameter int SAMC_W   = 5,
  parameter int DATA_W   = 10,
  parameter int NCH      = 4,
  parameter int CONV_TAD = 12,
  parameter int LOCK_TAD = 2,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              samp_req,
  input  logic [2:0]        src_sel,
  input  logic [SAMC_W-1:0] samp_clks,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              trig_tmr,
  input  logic              trig_pwm,
  input  logic              trig_ext,
  input  logic [DATA_W-1:0] conv_data,
  output logic [DATA_W-1:0] result,
  output logic              done,
  output logic [CH_W-1:0]   chan
);
  localparam int CV_W = $clog2(CONV_TAD + 1);
  localparam int PC_W = (SAMC_W > CV_W) ? SAMC_W : CV_W;

  typedef enum logic [1:0] {S_IDLE, S_SAMP, S_CONV, S_LOCK} st_t;
  st_t st, st_nx;

  logic [DIV_W-1:0] dcnt;
  logic [PC_W-1:0]  pcnt;
  logic [2:0]       sy1, sy2, sy3;
  logic             trig;

  wire              tick     = (dcnt == clk_div);
  wire [2:0]        rise     = sy2 & ~sy3;
  wire [SAMC_W-1:0] samc_eff = (samp_clks == '0) ? SAMC_W'(1) : samp_clks;
  wire              auto_due = tick && ((pcnt + PC_W'(1)) == PC_W'(samc_eff));
  wire              conv_end = tick && (pcnt == PC_W'(CONV_TAD - 1));
  wire              lock_end = tick && (pcnt == PC_W'(LOCK_TAD - 1));
  wire              active   = (st == S_SAMP) || (st == S_CONV);
  wire              abort    = active && !en;
  wire              fin      = (st == S_CONV) && en && conv_end;
  wire [CH_W-1:0]   chan_nx  = (chan == CH_W'(NCH - 1)) ? '0 : chan + 1'b1;

  always_comb begin
    case (src_sel)
      3'b000:  trig = !samp_req;
      3'b001:  trig = rise[0];
      3'b010:  trig = rise[1];
      3'b011:  trig = rise[2];
      3'b111:  trig = auto_due;
      default: trig = 1'b0;
    endcase
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (en && samp_req) st_nx = S_SAMP;
      S_SAMP: if (!en) st_nx = S_LOCK; else if (trig) st_nx = S_CONV;
      S_CONV: if (!en) st_nx = S_LOCK; else if (conv_end) st_nx = S_IDLE;
      default: if (lock_end) st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dcnt   <= '0;
      pcnt   <= '0;
      sy1    <= '0;
      sy2    <= '0;
      sy3    <= '0;
      result <= '0;
      done   <= 1'b0;
      chan   <= '0;
    end else begin
      st  <= st_nx;
      sy1 <= {trig_ext, trig_pwm, trig_tmr};
      sy2 <= sy1;
      sy3 <= sy2;
      if (st_nx != st) begin
        dcnt <= '0;
        pcnt <= '0;
      end else if (tick) begin
        dcnt <= '0;
        pcnt <= pcnt + 1'b1;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
      done <= fin;
      if (fin) result <= conv_data;
      if (fin || abort) chan <= chan_nx;
    end
  end
endmodule

module adc_seq_ctrl_chk #(
  parameter int DATA_W = 10,
  parameter int NCH    = 4,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic [CH_W-1:0]   chan
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R6
  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done); // R6
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chan <= CH_W'(NCH - 1)); // R8
  AST_CHAN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(chan) == CH_W'(NCH - 1)) |-> chan == '0); // R8
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.DATA_W(DATA_W), .NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .done(done), .result(result), .chan(chan)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int DIV_W = 6, SAMC_W = 5, DATA_W = 10, NCH = 3, CH_W = 2;

  logic clk = 0, rst_n = 0, en = 0, samp_req = 0;
  logic [2:0] src_sel = 0;
  logic [SAMC_W-1:0] samp_clks = 1;
  logic [DIV_W-1:0] clk_div = 0;
  logic trig_tmr = 0, trig_pwm = 0, trig_ext = 0;
  logic [DATA_W-1:0] conv_data = 0;
  wire [DATA_W-1:0] result;
  wire done;
  wire [CH_W-1:0] chan;

  adc_seq_ctrl #(.DIV_W(DIV_W), .SAMC_W(SAMC_W), .DATA_W(DATA_W), .NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .samp_req(samp_req), .src_sel(src_sel),
    .samp_clks(samp_clks), .clk_div(clk_div), .trig_tmr(trig_tmr), .trig_pwm(trig_pwm),
    .trig_ext(trig_ext), .conv_data(conv_data), .result(result), .done(done), .chan(chan)
  );

  int cyc = 0, n_chk = 0, n_bad = 0, n_done = 0, exp_ch = 0, last_res = 0;
  bit finished = 0;
  int q_at[$], q_data[$], q_ch[$];
  string q_tag[$];
  int m_at, m_data, m_ch;
  string m_tag;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic expect_done(int at, int data, string tag);
    exp_ch = (exp_ch + 1) % NCH;
    q_at.push_back(at); q_data.push_back(data); q_ch.push_back(exp_ch); q_tag.push_back(tag);
    last_res = data;
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (q_at.size() == 0) check(0, "R5 unexpected done", 1, 0);
      else begin
        m_at = q_at.pop_front(); m_data = q_data.pop_front();
        m_ch = q_ch.pop_front(); m_tag = q_tag.pop_front();
        check(cyc == m_at, {m_tag, " done cycle"}, cyc, m_at);
        check(int'(result) == m_data, {m_tag, " result R5"}, int'(result), m_data);
        check(int'(chan) == m_ch, {m_tag, " chan R8"}, int'(chan), m_ch);
      end
    end
  end

  task automatic run_auto(int d, int s, int data, string tag);
    int e0, se, at;
    @(negedge clk);
    clk_div = DIV_W'(d); samp_clks = SAMC_W'(s); src_sel = 3'b111;
    conv_data = DATA_W'(data); samp_req = 1;
    e0 = cyc + 1; se = (s == 0) ? 1 : s;
    at = e0 + (se + 12) * (d + 1);
    expect_done(at, data, tag);
    @(negedge clk); samp_req = 0;
    wait_to(at + 1);
  endtask

  task automatic run_sw(int d, int hold, int data, string tag);
    int at;
    @(negedge clk);
    clk_div = DIV_W'(d); src_sel = 3'b000; conv_data = DATA_W'(data); samp_req = 1;
    repeat (hold) @(negedge clk);
    samp_req = 0;
    at = cyc + 1 + 12 * (d + 1);
    expect_done(at, data, tag);
    wait_to(at + 1);
  endtask

  task automatic set_line(int w, logic v);
    case (w)
      0: trig_tmr = v;
      1: trig_pwm = v;
      default: trig_ext = v;
    endcase
  endtask

  task automatic run_ext(int d, int w, int data, string tag);
    int at;
    @(negedge clk);
    clk_div = DIV_W'(d); src_sel = 3'(w + 1); conv_data = DATA_W'(data); samp_req = 1;
    @(negedge clk); samp_req = 0;
    repeat (4) @(negedge clk);
    set_line(w, 1'b1);
    at = cyc + 3 + 12 * (d + 1);
    expect_done(at, data, tag);
    wait_to(at + 1);
    set_line(w, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  // after abort edge a: request again at once; lockout must hold it off (R7)
  task automatic restart(int a, int d, int s, int data, string tag);
    int l, se, at;
    en = 1; samp_req = 1; conv_data = DATA_W'(data);
    se = (s == 0) ? 1 : s;
    l = a + 2 * (d + 1);
    wait_to(l + 1);
    samp_req = 0;
    at = (l + 1) + (se + 12) * (d + 1);
    expect_done(at, data, tag);
    wait_to(at + 1);
  endtask

  task automatic abort_conv(int d, int s, int data);
    int e0, se, c, a;
    @(negedge clk);
    clk_div = DIV_W'(d); samp_clks = SAMC_W'(s); src_sel = 3'b111;
    conv_data = DATA_W'(1023); samp_req = 1;
    e0 = cyc + 1; se = (s == 0) ? 1 : s;
    @(negedge clk); samp_req = 0;
    c = e0 + se * (d + 1);
    wait_to(c + 3);
    en = 0; a = cyc + 1;
    exp_ch = (exp_ch + 1) % NCH;
    @(negedge clk);
    check(int'(result) == last_res, "R6 result kept after abort", int'(result), last_res);
    restart(a, d, s, data, "R7 restart after conversion abort");
  endtask

  task automatic coincide(int d, int s, int data);
    int e0, se, f;
    @(negedge clk);
    clk_div = DIV_W'(d); samp_clks = SAMC_W'(s); src_sel = 3'b111;
    conv_data = DATA_W'(1022); samp_req = 1;
    e0 = cyc + 1; se = (s == 0) ? 1 : s;
    @(negedge clk); samp_req = 0;
    f = e0 + se * (d + 1);
    wait_to(f - 1);
    en = 0;
    exp_ch = (exp_ch + 1) % NCH;
    @(negedge clk);
    check(int'(result) == last_res, "R6 abort beats auto-start", int'(result), last_res);
    restart(f, d, s, data, "R6 R7 restart after coinciding abort");
  endtask

  task automatic reserved_src(int d, int data);
    int n0, a;
    @(negedge clk);
    clk_div = DIV_W'(d); src_sel = 3'b101; samp_req = 1;
    @(negedge clk); samp_req = 0;
    n0 = n_done;
    trig_tmr = 1; trig_ext = 1;
    repeat (100) @(negedge clk);
    check(n_done == n0, "R4 reserved code starts nothing", n_done - n0, 0);
    trig_tmr = 0; trig_ext = 0;
    en = 0; a = cyc + 1;
    exp_ch = (exp_ch + 1) % NCH;
    @(negedge clk);
    src_sel = 3'b111; samp_clks = SAMC_W'(2);
    restart(a, d, 2, data, "R7 restart after reserved-code abort");
  endtask

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      check(0, "R5 watchdog expired", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(result == '0, "R9 reset result", int'(result), 0);
    check(done == 1'b0, "R9 reset done", int'(done), 0);
    check(chan == '0, "R9 reset chan", int'(chan), 0);
    rst_n = 1; en = 1;
    @(negedge clk);
    run_auto(0, 1, 11, "R3 auto samc1 div0 (13 Tad)");
    run_auto(2, 1, 22, "R1 R3 auto samc1 div2");
    run_auto(1, 4, 33, "R3 auto samc4 div1");
    run_auto(0, 0, 44, "R3 auto samc0 acts as 1");
    run_auto(5, 3, 55, "R1 auto samc3 div5");
    run_sw(0, 5, 66, "R2 software div0");
    run_sw(3, 2, 77, "R2 R5 software div3");
    run_ext(1, 0, 88, "R4 timer line");
    run_ext(0, 1, 99, "R4 pwm line");
    run_ext(2, 2, 111, "R4 interrupt line");
    abort_conv(1, 2, 222);
    coincide(2, 3, 333);
    reserved_src(1, 444);
    run_auto(63, 1, 555, "R1 max divider");
    repeat (5) @(negedge clk);
    check(q_at.size() == 0, "R5 pending done pulses", q_at.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule